// File: doc/BRIEF.md
# Low-Power Mode Reset Controller

This block keeps track of the chip's power mode. The four modes are run, wait, doze and stop. From the same state it produces the chip reset and the clock enables for the CPU, flash, RAM and peripherals.

The CPU asks for a low-power mode with three request lines. Any qualified reset source returns the block to run, raises a one-cycle exit pulse when it ends a low-power mode, and records its own identity in a cause code. Which sources count depends on the mode:
- The external reset pin passes a synchronizer and a consecutive-cycle filter in run, wait and doze.
- In stop, the pin asserts the reset asynchronously, and the reset is released synchronously.
- The watchdog counts only while its enable is held and the mode is not stop.
- A software request counts only in run, where the CPU is executing.
- A loss of clock or lock counts only while the PLL is marked active.

After the last source goes away, the reset output stays asserted for a fixed stretch. When the PLL is configured to power down in stop, leaving stop keeps all clock enables low for a programmable relock count.

Top module: `lpm_reset_ctrl`

## Requirements
- R1: While `por_i` is high, `rst_o` is high and the mode returns to run. The cause code becomes 0. If the mode was wait, doze or stop, `exit_o` pulses.
- R2: In run, wait and doze, the pin `pin_rst_i` causes a reset only after it has been sampled high on FILT_LEN (default 4) consecutive clock edges. A pulse of FILT_LEN-1 edges has no effect.
- R3: In stop, a high level on `pin_rst_i` drives `rst_o` high with no clock edge needed. At the next edge the mode leaves stop and `exit_o` pulses.
- R4: A pulse on `pll_loc_i` or `pll_lol_i` resets the chip in any mode while `pll_on_i` is high, and is ignored while `pll_on_i` is low.
- R5: The chip resets on `wdt_tmo_i` only when `wdt_en_i` is high and the mode is run, wait or doze. A timeout in stop, or with the enable low, has no effect.
- R6: `sw_rst_i` resets the chip only in run. In wait, doze and stop it is ignored, and the mode and clock enables are left unchanged.
- R7: In wait and doze, `cpu_ce_o`, `flash_ce_o` and `ram_ce_o` are low and `per_ce_o` is high.
- R8: In stop, all four clock enables are low.
- R9: A source active for one clock edge holds `rst_o` high for STRETCH+1 cycles, which is 9 with the default STRETCH of 8.
- R10: If stop is left with `pll_stop_off_i` high, `cpu_ce_o` comes back N+1 cycles after the `exit_o` pulse, where N is `relock_cycles_i`. With `pll_stop_off_i` low it comes back after 1 cycle.
- R11: `exit_o` is high for exactly one cycle, together with `rst_o`, and only when a reset ends wait, doze or stop. A reset taken in run gives no pulse.
- R12: `cause_o` holds the highest-priority source of the last reset, using the codes power-on 0, pin 1, PLL 2, watchdog 3, software 4. Lower codes win when several sources are active at once.
- R13: Mode requests are taken only in run, and only while no reset or relock is active. When several are raised together, stop wins over doze, and doze wins over wait. The clock enables follow one cycle after the mode changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-running controller clock |
| por_i | input | 1 | Power-on reset, active high, synchronous |
| pin_rst_i | input | 1 | External reset pin level, active high |
| pll_on_i | input | 1 | PLL is active |
| pll_loc_i | input | 1 | PLL loss of clock |
| pll_lol_i | input | 1 | PLL loss of lock |
| wdt_en_i | input | 1 | Watchdog enabled |
| wdt_tmo_i | input | 1 | Watchdog timeout |
| sw_rst_i | input | 1 | Software reset request |
| req_wait_i | input | 1 | Request to enter wait |
| req_doze_i | input | 1 | Request to enter doze |
| req_stop_i | input | 1 | Request to enter stop |
| pll_stop_off_i | input | 1 | PLL powers down in stop, so relock is needed on exit |
| relock_cycles_i | input | RELOCK_W | Relock interval in clock cycles |
| rst_o | output | 1 | Chip reset |
| exit_o | output | 1 | One-cycle low-power exit pulse |
| cause_o | output | 3 | Cause code of the last reset |
| cpu_ce_o | output | 1 | CPU clock enable |
| flash_ce_o | output | 1 | Flash clock enable |
| ram_ce_o | output | 1 | RAM clock enable |
| per_ce_o | output | 1 | Peripheral clock enable |

## Verification
Each reset source is applied once in every mode where its treatment differs. The table pairs each mode with each source, so a source that is honoured everywhere can be told apart from one whose gating by mode is missing or reversed. The pin is driven for four cycles and for three cycles, which separates a filter of the correct length from one that is one cycle off. Stop-mode wakeups are run with and without relock, which separates the two restore latencies. Further cases set the pin mid-cycle to expose the path that needs no clock, and raise two sources or two requests in the same cycle to check the priorities.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
  typedef enum logic [1:0] {
    MODE_RUN  = 2'd0,
    MODE_WAIT = 2'd1,
    MODE_DOZE = 2'd2,
    MODE_STOP = 2'd3
  } lpm_mode_e;

  typedef enum logic [2:0] {
    CAUSE_POR = 3'd0,
    CAUSE_PIN = 3'd1,
    CAUSE_PLL = 3'd2,
    CAUSE_WDT = 3'd3,
    CAUSE_SW  = 3'd4
  } lpm_cause_e;
endpackage

// File: rtl/lpm_pin_filter.sv
// External pin conditioning: a synchronized and filtered path for run, wait
// and doze, plus an asynchronous-assert, synchronous-release path for stop.
module lpm_pin_filter #(
  parameter int FILT_LEN = 4
) (
  input  logic clk,
  input  logic por_i,
  input  logic pin_i,
  input  logic stop_i,
  output logic hit_sync_o,
  output logic hit_async_o
);
  localparam int CW = $clog2(FILT_LEN + 1);
  localparam logic [CW-1:0] RUN_MAX = CW'(FILT_LEN - 1);

  logic [1:0]    sync_q;
  logic [CW-1:0] run_q;
  logic [1:0]    ar_q;
  logic          aset;

  assign aset = pin_i & stop_i;

  always_ff @(posedge clk) begin
    if (por_i) begin
      sync_q <= '0;
      run_q  <= '0;
    end else begin
      sync_q <= {sync_q[0], pin_i};
      if (!sync_q[1])
        run_q <= '0;
      else if (run_q != RUN_MAX)
        run_q <= run_q + 1'b1;
    end
  end

  // Asserted at once by the pin while in stop; released over two edges.
  always_ff @(posedge clk or posedge aset) begin
    if (aset)
      ar_q <= 2'b11;
    else if (por_i)
      ar_q <= 2'b00;
    else
      ar_q <= {ar_q[0], 1'b0};
  end

  assign hit_sync_o  = sync_q[1] && (run_q == RUN_MAX) && !stop_i;
  assign hit_async_o = ar_q[1];
endmodule

// File: rtl/lpm_reset_gen.sv
// Qualifies each reset source against the current mode, stretches the
// chip reset and records the winning cause.
module lpm_reset_gen
  import lpm_pkg::*;
#(
  parameter int STRETCH = 8
) (
  input  logic      clk,
  input  logic      por_i,
  input  lpm_mode_e mode_i,
  input  logic      pin_sync_i,
  input  logic      pin_async_i,
  input  logic      pll_on_i,
  input  logic      pll_loc_i,
  input  logic      pll_lol_i,
  input  logic      wdt_en_i,
  input  logic      wdt_tmo_i,
  input  logic      sw_rst_i,
  output logic      src_any_o,
  output logic      rst_o,
  output logic [2:0] cause_o
);
  localparam int SW_W = $clog2(STRETCH + 1);
  localparam logic [SW_W-1:0] STRETCH_V = SW_W'(STRETCH);

  logic s_pin, s_pll, s_wdt, s_sw;
  logic [SW_W-1:0] hold_q;
  logic rst_q;
  lpm_cause_e cause_d, cause_q;

  assign s_pin = pin_sync_i | pin_async_i;
  assign s_pll = pll_on_i & (pll_loc_i | pll_lol_i);
  assign s_wdt = wdt_tmo_i & wdt_en_i & (mode_i != MODE_STOP);
  assign s_sw  = sw_rst_i & (mode_i == MODE_RUN);
  assign src_any_o = por_i | s_pin | s_pll | s_wdt | s_sw;

  always_comb begin
    if (por_i)      cause_d = CAUSE_POR;
    else if (s_pin) cause_d = CAUSE_PIN;
    else if (s_pll) cause_d = CAUSE_PLL;
    else if (s_wdt) cause_d = CAUSE_WDT;
    else            cause_d = CAUSE_SW;
  end

  always_ff @(posedge clk) begin
    if (src_any_o) begin
      hold_q  <= STRETCH_V;
      rst_q   <= 1'b1;
      cause_q <= cause_d;
    end else if (hold_q != '0) begin
      hold_q <= hold_q - 1'b1;
      rst_q  <= 1'b1;
    end else begin
      rst_q <= 1'b0;
    end
  end

  assign rst_o   = rst_q | pin_async_i;
  assign cause_o = cause_q;
endmodule

// File: rtl/lpm_mode_clk.sv
// Mode register, exit pulse, relock wait and registered clock enables.
module lpm_mode_clk
  import lpm_pkg::*;
#(
  parameter int RELOCK_W = 16
) (
  input  logic                clk,
  input  logic                por_i,
  input  logic                src_any_i,
  input  logic                rst_busy_i,
  input  logic                req_wait_i,
  input  logic                req_doze_i,
  input  logic                req_stop_i,
  input  logic                pll_stop_off_i,
  input  logic [RELOCK_W-1:0] relock_cycles_i,
  output lpm_mode_e           mode_o,
  output logic                exit_o,
  output logic                cpu_ce_o,
  output logic                flash_ce_o,
  output logic                ram_ce_o,
  output logic                per_ce_o
);
  lpm_mode_e mode_q;
  logic [RELOCK_W-1:0] relock_q;
  logic exit_q;
  logic core_on, per_on;
  logic [3:0] ce_q;

  always_ff @(posedge clk) begin
    if (por_i) begin
      mode_q   <= MODE_RUN;
      exit_q   <= (mode_q != MODE_RUN);
      relock_q <= '0;
    end else if (src_any_i) begin
      mode_q <= MODE_RUN;
      exit_q <= (mode_q != MODE_RUN);
      if (mode_q == MODE_STOP && pll_stop_off_i)
        relock_q <= relock_cycles_i;
      else if (relock_q != '0)
        relock_q <= relock_q - 1'b1;
    end else begin
      exit_q <= 1'b0;
      if (relock_q != '0)
        relock_q <= relock_q - 1'b1;
      if (mode_q == MODE_RUN && !rst_busy_i && relock_q == '0) begin
        if (req_stop_i)      mode_q <= MODE_STOP;
        else if (req_doze_i) mode_q <= MODE_DOZE;
        else if (req_wait_i) mode_q <= MODE_WAIT;
      end
    end
  end

  assign core_on = (mode_q == MODE_RUN) && (relock_q == '0);
  assign per_on  = (mode_q != MODE_STOP) && (relock_q == '0);

  // Bits 0..2 follow the core domain, bit 3 the peripheral domain.
  for (genvar g = 0; g < 4; g++) begin : g_ce
    always_ff @(posedge clk) begin
      if (por_i)
        ce_q[g] <= 1'b1;
      else
        ce_q[g] <= (g == 3) ? per_on : core_on;
    end
  end

  assign mode_o     = mode_q;
  assign exit_o     = exit_q;
  assign cpu_ce_o   = ce_q[0];
  assign flash_ce_o = ce_q[1];
  assign ram_ce_o   = ce_q[2];
  assign per_ce_o   = ce_q[3];
endmodule

// File: rtl/lpm_reset_ctrl.sv
module lpm_reset_ctrl
  import lpm_pkg::*;
#(
  parameter int FILT_LEN = 4,
  parameter int STRETCH  = 8,
  parameter int RELOCK_W = 16
) (
  input  logic                clk,
  input  logic                por_i,
  input  logic                pin_rst_i,
  input  logic                pll_on_i,
  input  logic                pll_loc_i,
  input  logic                pll_lol_i,
  input  logic                wdt_en_i,
  input  logic                wdt_tmo_i,
  input  logic                sw_rst_i,
  input  logic                req_wait_i,
  input  logic                req_doze_i,
  input  logic                req_stop_i,
  input  logic                pll_stop_off_i,
  input  logic [RELOCK_W-1:0] relock_cycles_i,
  output logic                rst_o,
  output logic                exit_o,
  output logic [2:0]          cause_o,
  output logic                cpu_ce_o,
  output logic                flash_ce_o,
  output logic                ram_ce_o,
  output logic                per_ce_o
);
  lpm_mode_e mode_q;
  logic pin_sync, pin_async, src_any;

  lpm_pin_filter #(.FILT_LEN(FILT_LEN)) u_pin (
    .clk        (clk),
    .por_i      (por_i),
    .pin_i      (pin_rst_i),
    .stop_i     (mode_q == MODE_STOP),
    .hit_sync_o (pin_sync),
    .hit_async_o(pin_async)
  );

  lpm_reset_gen #(.STRETCH(STRETCH)) u_rst (
    .clk        (clk),
    .por_i      (por_i),
    .mode_i     (mode_q),
    .pin_sync_i (pin_sync),
    .pin_async_i(pin_async),
    .pll_on_i   (pll_on_i),
    .pll_loc_i  (pll_loc_i),
    .pll_lol_i  (pll_lol_i),
    .wdt_en_i   (wdt_en_i),
    .wdt_tmo_i  (wdt_tmo_i),
    .sw_rst_i   (sw_rst_i),
    .src_any_o  (src_any),
    .rst_o      (rst_o),
    .cause_o    (cause_o)
  );

  lpm_mode_clk #(.RELOCK_W(RELOCK_W)) u_mode (
    .clk            (clk),
    .por_i          (por_i),
    .src_any_i      (src_any),
    .rst_busy_i     (rst_o),
    .req_wait_i     (req_wait_i),
    .req_doze_i     (req_doze_i),
    .req_stop_i     (req_stop_i),
    .pll_stop_off_i (pll_stop_off_i),
    .relock_cycles_i(relock_cycles_i),
    .mode_o         (mode_q),
    .exit_o         (exit_o),
    .cpu_ce_o       (cpu_ce_o),
    .flash_ce_o     (flash_ce_o),
    .ram_ce_o       (ram_ce_o),
    .per_ce_o       (per_ce_o)
  );
endmodule

// File: rtl/lpm_reset_ctrl_chk.sv
module lpm_reset_ctrl_chk
  import lpm_pkg::*;
(
  input logic      clk,
  input logic      por_i,
  input lpm_mode_e mode_q,
  input logic      rst_o,
  input logic      exit_o,
  input logic      cpu_ce_o,
  input logic      per_ce_o
);
  // R7 / R8: the core clock never runs while the peripheral clock is off
  assert_core_needs_per_R8: assert property (@(posedge clk) disable iff (por_i)
    cpu_ce_o |-> per_ce_o);

  // R11: exit pulse lasts one cycle
  assert_exit_single_R11: assert property (@(posedge clk) disable iff (por_i)
    exit_o |=> !exit_o);

  // R11: exit pulse only comes with a chip reset
  assert_exit_with_reset_R11: assert property (@(posedge clk) disable iff (por_i)
    exit_o |-> rst_o);

  // R8: stop mode turns off the peripheral clock
  assert_stop_per_off_R8: assert property (@(posedge clk) disable iff (por_i)
    (mode_q == MODE_STOP) |=> !per_ce_o);

  // R7: wait and doze keep peripherals clocked, core stopped
  assert_idle_clocks_R7: assert property (@(posedge clk) disable iff (por_i)
    (mode_q == MODE_WAIT || mode_q == MODE_DOZE) |=> (!cpu_ce_o && per_ce_o));
endmodule

bind lpm_reset_ctrl lpm_reset_ctrl_chk chk_i (
  .clk     (clk),
  .por_i   (por_i),
  .mode_q  (mode_q),
  .rst_o   (rst_o),
  .exit_o  (exit_o),
  .cpu_ce_o(cpu_ce_o),
  .per_ce_o(per_ce_o)
);

// File: tb/lpm_reset_ctrl_tb.sv
module lpm_reset_ctrl_tb_top;
  localparam int RW = 16;

  logic clk = 1'b0;
  logic por_i = 1'b1, pin_rst_i = 0, pll_on_i = 0, pll_loc_i = 0, pll_lol_i = 0;
  logic wdt_en_i = 0, wdt_tmo_i = 0, sw_rst_i = 0;
  logic req_wait_i = 0, req_doze_i = 0, req_stop_i = 0, pll_stop_off_i = 0;
  logic [RW-1:0] relock_cycles_i = '0;
  logic rst_o, exit_o, cpu_ce_o, flash_ce_o, ram_ce_o, per_ce_o;
  logic [2:0] cause_o;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #4 clk = ~clk;

  lpm_reset_ctrl #(.RELOCK_W(RW)) dut_i (.*);

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_por();
    @(negedge clk); por_i = 1;
    cyc(3);
    por_i = 0;
    cyc(12);
  endtask

  // mode: 0 run 1 wait 2 doze 3 stop
  task automatic enter_mode(input int m);
    if (m == 0) return;
    @(negedge clk);
    req_wait_i = (m == 1); req_doze_i = (m == 2); req_stop_i = (m == 3);
    @(negedge clk);
    req_wait_i = 0; req_doze_i = 0; req_stop_i = 0;
    cyc(3);
  endtask

  // vector: {mode[1:0], src[2:0], exp_rst, exp_cause[2:0]}
  // src: 0 sw, 1 wdt enabled, 2 wdt disabled, 3 pll loss active, 4 pll loss inactive,
  //      5 pin 4 cycles, 6 pin 3 cycles
  localparam int NV = 13;
  localparam logic [8:0] VEC [NV] = '{
    {2'd0, 3'd0, 1'b1, 3'd4},  // R6 sw in run
    {2'd1, 3'd0, 1'b0, 3'd0},  // R6 sw in wait
    {2'd2, 3'd0, 1'b0, 3'd0},  // R6 sw in doze
    {2'd1, 3'd1, 1'b1, 3'd3},  // R5 wdt in wait
    {2'd2, 3'd2, 1'b0, 3'd0},  // R5 wdt disabled in doze
    {2'd3, 3'd1, 1'b0, 3'd0},  // R5 wdt in stop
    {2'd0, 3'd3, 1'b1, 3'd2},  // R4 pll loss in run
    {2'd3, 3'd3, 1'b1, 3'd2},  // R4 pll loss in stop
    {2'd1, 3'd4, 1'b0, 3'd0},  // R4 pll inactive in wait
    {2'd0, 3'd5, 1'b1, 3'd1},  // R2 pin filtered in run
    {2'd2, 3'd5, 1'b1, 3'd1},  // R2 pin filtered in doze
    {2'd1, 3'd6, 1'b0, 3'd0},  // R2 short pin in wait
    {2'd3, 3'd0, 1'b0, 3'd0}   // R6 sw in stop
  };

  task automatic run_vec(input logic [8:0] v);
    int m, s, len;
    bit saw_rst, saw_exit;
    m = int'(v[8:7]); s = int'(v[6:4]);
    saw_rst = 0; saw_exit = 0;
    do_por();
    enter_mode(m);
    len = (s == 5) ? 4 : (s == 6) ? 3 : 1;
    for (int c = 0; c < 20; c++) begin
      @(negedge clk);
      saw_rst  |= rst_o;
      saw_exit |= exit_o;
      if (c < len) begin
        sw_rst_i  = (s == 0);
        wdt_tmo_i = (s == 1 || s == 2); wdt_en_i = (s == 1);
        pll_loc_i = (s == 3 || s == 4); pll_on_i = (s == 3);
        pin_rst_i = (s == 5 || s == 6);
      end else begin
        sw_rst_i = 0; wdt_tmo_i = 0; wdt_en_i = 0;
        pll_loc_i = 0; pll_on_i = 0; pin_rst_i = 0;
      end
    end
    check($sformatf("R4/R5/R6/R2 vec m%0d s%0d reset", m, s), int'(saw_rst), int'(v[3]));
    if (v[3]) begin
      check("R12 vec cause", int'(cause_o), int'(v[2:0]));
      check("R11 vec exit", int'(saw_exit), int'(m != 0));
    end else begin
      check("R11 vec no exit", int'(saw_exit), 0);
      check("R12 vec cause unchanged", int'(cause_o), 0);
      check("R6 vec core ce unchanged", int'(cpu_ce_o), int'(m == 0));
      check("R7/R8 vec per ce", int'(per_ce_o), int'(m != 3));
    end
  endtask

  initial begin
    int n;
    // R1: reset state
    cyc(2);
    check("R1 rst during por", int'(rst_o), 1);
    check("R12 cause por", int'(cause_o), 0);
    por_i = 0;
    cyc(12);
    check("R1 rst released", int'(rst_o), 0);
    check("R1 exit idle", int'(exit_o), 0);
    check("R1 clocks on", int'({cpu_ce_o, flash_ce_o, ram_ce_o, per_ce_o}), 15);

    foreach (VEC[i]) run_vec(VEC[i]);

    // R9: stretch length from one-cycle software reset
    do_por();
    @(negedge clk); sw_rst_i = 1;
    @(negedge clk); sw_rst_i = 0;
    n = 0;
    while (rst_o && n < 50) begin n++; @(negedge clk); end
    check("R9 stretch cycles", n, 9);

    // R7 then R1: por ends wait with exit pulse
    do_por();
    enter_mode(1);
    check("R7 wait clocks", int'({cpu_ce_o, flash_ce_o, ram_ce_o, per_ce_o}), 1);
    @(negedge clk); por_i = 1;
    @(negedge clk);
    check("R1 exit on por", int'(exit_o), 1);
    check("R1 rst on por", int'(rst_o), 1);
    por_i = 0;
    cyc(12);

    // R8 / R3 / R10: async pin in stop, no relock
    do_por();
    enter_mode(3);
    check("R8 stop clocks", int'({cpu_ce_o, flash_ce_o, ram_ce_o, per_ce_o}), 0);
    @(negedge clk); pin_rst_i = 1;
    #1;
    check("R3 async rst", int'(rst_o), 1);
    @(negedge clk); pin_rst_i = 0;
    check("R3 exit pulse", int'(exit_o), 1);
    n = 0;
    while (!cpu_ce_o && n < 100) begin n++; @(negedge clk); end
    check("R10 no relock restore", n, 1);
    cyc(12);

    // R10: relock of 20 cycles
    pll_stop_off_i = 1; relock_cycles_i = 16'd20;
    do_por();
    enter_mode(3);
    @(negedge clk); pin_rst_i = 1;
    @(negedge clk); pin_rst_i = 0;
    check("R10 exit pulse", int'(exit_o), 1);
    n = 0;
    while (!cpu_ce_o && n < 100) begin n++; @(negedge clk); end
    check("R10 relock restore", n, 21);
    pll_stop_off_i = 0;
    cyc(12);

    // R13: stop wins over wait
    do_por();
    @(negedge clk); req_stop_i = 1; req_wait_i = 1;
    @(negedge clk); req_stop_i = 0; req_wait_i = 0;
    cyc(2);
    check("R13 priority stop", int'(per_ce_o), 0);
    check("R13 priority core", int'(cpu_ce_o), 0);

    // R13: doze wins over wait
    do_por();
    @(negedge clk); req_doze_i = 1; req_wait_i = 1;
    @(negedge clk); req_doze_i = 0; req_wait_i = 0;
    cyc(2);
    check("R13 doze per on", int'(per_ce_o), 1);
    check("R13 doze core off", int'(cpu_ce_o), 0);

    // R13: request blocked during reset
    do_por();
    @(negedge clk); sw_rst_i = 1;
    @(negedge clk); sw_rst_i = 0; req_wait_i = 1;
    @(negedge clk); req_wait_i = 0;
    cyc(14);
    check("R13 blocked in reset", int'(cpu_ce_o), 1);

    // R12: PLL beats software in the same cycle
    do_por();
    @(negedge clk); sw_rst_i = 1; pll_on_i = 1; pll_lol_i = 1;
    @(negedge clk); sw_rst_i = 0; pll_on_i = 0; pll_lol_i = 0;
    check("R12 priority pll", int'(cause_o), 2);
    check("R11 no exit in run", int'(exit_o), 0);
    cyc(12);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule